// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a fully associative cache of page translations that holds entries for several address spaces at the same time. Each entry maps one 4 KB virtual page to a physical page. It also stores the address-space identifier (ASID) of its owner and a global flag. Because entries carry their owner's tag, switching between processes does not have to discard the whole cache. Translations of a process that was switched out are still present when that process is scheduled again.

The lookup port takes a 64-bit virtual address and the current ASID. One cycle later it returns hit, miss, or a canonical-form fault, together with the physical address. The fill port installs a translation after a page walk. The control port handles four operations:
- a write of the page-table base in tagged mode;
- a write of the page-table base in untagged mode;
- invalidation of one page within one ASID;
- invalidation of a whole ASID.

Top module: `tlb_tagged`

## Requirements
- R1: After synchronous reset every entry is invalid, `lk_valid` is low, and the first lookup after reset misses.
- R2: A lookup presented with `lk_req` high is answered on the following cycle with `lk_valid` high. On a hit, `lk_pa` equals the stored 28-bit physical page number concatenated with the untranslated address bits 11:0. The lookup sees the table as it stood before that same clock edge.
- R3: A non-global entry hits only when its 36-bit page number equals address bits 47:12 and its ASID equals `cur_asid`.
- R4: A global entry hits on a page-number match whatever `cur_asid` is.
- R5: An address is canonical when bits 63 down to 47 are all equal. A non-canonical lookup returns `lk_fault` high and `lk_hit` low.
- R6: `ctl_op` = 2 (page-table base write, tagged) invalidates nothing. `ctl_op` = 1 (page-table base write, untagged) invalidates every non-global entry, and global entries survive.
- R7: `ctl_op` = 3 invalidates the entry whose page number equals `ctl_vpn` and whose ASID equals `ctl_asid`, or a global entry with that page number. No other entry is affected.
- R8: `ctl_op` = 4 invalidates every non-global entry whose ASID equals `ctl_asid`. Global entries are not affected.
- R9: A fill whose page number and ASID equal those of a valid entry overwrites that entry, so later lookups return the new physical page.
- R10: A fill issued in the same cycle as `ctl_op` 1, 3 or 4 is discarded.
- R11: A fill is placed in the lowest-numbered invalid entry. When no entry is invalid, it replaces the entry under a round-robin pointer that starts at entry 0 after reset and advances by one, wrapping, on each such replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address to translate |
| cur_asid | input | 8 | ASID of the running process |
| lk_valid | output | 1 | Lookup result present (registered) |
| lk_hit | output | 1 | Translation found |
| lk_fault | output | 1 | Address not in canonical form |
| lk_pa | output | 40 | Physical address |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 36 | Virtual page number to install |
| fill_asid | input | 8 | ASID of the installed entry |
| fill_ppn | input | 28 | Physical page number to install |
| fill_global | input | 1 | Installed entry is global |
| ctl_op | input | 3 | 0 none, 1 untagged base write, 2 tagged base write, 3 page invalidate, 4 ASID invalidate |
| ctl_vpn | input | 36 | Page number for a page invalidate |
| ctl_asid | input | 8 | ASID for page or ASID invalidate |

## Verification
Lookup results are due exactly one cycle after the request edge. Fills and control operations change the table at the first edge after they are driven. The bench therefore drives every operation on a falling edge and holds it for one cycle. A lookup that must observe an update is only issued after that update's edge. Each lookup pushes its expected hit, fault and address into a queue. A monitor pops that queue on each falling edge where `lk_valid` is high, so every result is compared in the single cycle it belongs to.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_BASE_UNTG = 3'd1,
    OP_BASE_TAG  = 3'd2,
    OP_INV_PAGE  = 3'd3,
    OP_INV_ASID  = 3'd4
  } ctl_op_e;

  localparam int unsigned PAGE_BITS = 12;
endpackage

// File: rtl/tlb_canon.sv
module tlb_canon #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned VA_W   = 48
) (
  input  logic [WORD_W-1:0] va,
  output logic              ok
);
  localparam int unsigned HI_W = WORD_W - VA_W + 1;
  logic [HI_W-1:0] hi;
  assign hi = va[WORD_W-1:VA_W-1];
  assign ok = (&hi) | ~(|hi);
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N      = 96,
  parameter int unsigned VPN_W  = 36,
  parameter int unsigned ASID_W = 8
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [N-1:0]      ent_glob,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              exact,
  output logic [N-1:0]      match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic vpn_eq, asid_eq;
    assign vpn_eq   = (ent_vpn[g] == key_vpn);
    assign asid_eq  = (ent_asid[g] == key_asid);
    assign match[g] = ent_valid[g] & vpn_eq & (asid_eq | (~exact & ent_glob[g]));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 96,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  ent_valid,
  input  logic          dup_hit,
  input  logic [IW-1:0] dup_idx,
  input  logic          fill_do,
  output logic [IW-1:0] widx
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_idx   = IW'(i);
        free_found = 1'b1;
      end
    end
  end

  always_comb begin
    if (dup_hit)         widx = dup_idx;
    else if (free_found) widx = free_idx;
    else                 widx = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fill_do && !dup_hit && !free_found)
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R11
  rr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rr_q < IW'(N));

  // R11
  rr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_do && !dup_hit && !free_found && rr_q != IW'(N - 1)) |=> rr_q == $past(rr_q) + 1'b1);
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged #(
  parameter int unsigned ENTRIES = 96,
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned VA_W    = 48,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PPN_W   = 28,
  localparam int unsigned VPN_W  = VA_W - tlb_pkg::PAGE_BITS,
  localparam int unsigned PA_W   = PPN_W + tlb_pkg::PAGE_BITS,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [WORD_W-1:0] lk_va,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_pa,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_global,
  input  logic [2:0]        ctl_op,
  input  logic [VPN_W-1:0]  ctl_vpn,
  input  logic [ASID_W-1:0] ctl_asid
);
  import tlb_pkg::*;
  localparam int unsigned PB = tlb_pkg::PAGE_BITS;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_q;
  logic [VPN_W-1:0]   vpn_mem  [ENTRIES];
  logic [ASID_W-1:0]  asid_mem [ENTRIES];
  logic [PPN_W-1:0]   ppn_mem  [ENTRIES];

  ctl_op_e op;
  assign op = ctl_op_e'(ctl_op);

  // lookup path
  logic              canon_ok;
  logic [ENTRIES-1:0] lk_match;
  logic [VPN_W-1:0]  lk_vpn;
  logic              lk_any;
  logic [IW-1:0]     lk_idx;

  assign lk_vpn = lk_va[VA_W-1:PB];

  tlb_canon #(.WORD_W(WORD_W), .VA_W(VA_W)) u_canon (
    .va(lk_va), .ok(canon_ok)
  );

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .ent_valid(valid_q), .ent_glob(glob_q), .ent_vpn(vpn_mem), .ent_asid(asid_mem),
    .key_vpn(lk_vpn), .key_asid(cur_asid), .exact(1'b0), .match(lk_match)
  );

  always_comb begin
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) lk_idx = IW'(i);
  end
  assign lk_any = |lk_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_fault <= 1'b0;
      lk_pa    <= '0;
    end else begin
      lk_valid <= lk_req;
      lk_hit   <= lk_req & canon_ok & lk_any;
      lk_fault <= lk_req & ~canon_ok;
      lk_pa    <= {ppn_mem[lk_idx], lk_va[PB-1:0]};
    end
  end

  // fill path
  logic [ENTRIES-1:0] fill_match;
  logic              dup_hit;
  logic [IW-1:0]     dup_idx;
  logic [IW-1:0]     widx;
  logic              kill_fill;
  logic              fill_do;

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
    .ent_valid(valid_q), .ent_glob(glob_q), .ent_vpn(vpn_mem), .ent_asid(asid_mem),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .exact(1'b1), .match(fill_match)
  );

  always_comb begin
    dup_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (fill_match[i]) dup_idx = IW'(i);
  end
  assign dup_hit   = |fill_match;
  assign kill_fill = (op == OP_BASE_UNTG) || (op == OP_INV_PAGE) || (op == OP_INV_ASID);
  assign fill_do   = fill_en & ~kill_fill;

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .ent_valid(valid_q), .dup_hit(dup_hit),
    .dup_idx(dup_idx), .fill_do(fill_do), .widx(widx)
  );

  // payload storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (fill_do) begin
      vpn_mem[widx]  <= fill_vpn;
      asid_mem[widx] <= fill_asid;
      ppn_mem[widx]  <= fill_ppn;
    end
  end

  // valid and global flags
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        unique case (op)
          OP_BASE_UNTG: if (!glob_q[i]) valid_q[i] <= 1'b0;
          OP_INV_PAGE:
            if (vpn_mem[i] == ctl_vpn && (asid_mem[i] == ctl_asid || glob_q[i]))
              valid_q[i] <= 1'b0;
          OP_INV_ASID:
            if (asid_mem[i] == ctl_asid && !glob_q[i]) valid_q[i] <= 1'b0;
          default: ;
        endcase
      end
      if (fill_do) begin
        valid_q[widx] <= 1'b1;
        glob_q[widx]  <= fill_global;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0 && !lk_valid));

  // R2
  lookup_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid);

  // R5
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> !(lk_hit && lk_fault));

  // R6
  untag_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BASE_UNTG) |=> ((valid_q & ~glob_q) == '0));

  // R6
  tag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BASE_TAG && !fill_en) |=> $stable(valid_q));

  // R9
  fill_unique_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> $onehot0(fill_match));

  // R10
  fill_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && op == OP_BASE_UNTG) |=> ((valid_q & ~glob_q) == '0));
endmodule

// File: tb/tb_tlb_tagged.sv
module tb_tlb_tagged;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [63:0] lk_va = '0;
  logic [7:0]  cur_asid = '0;
  logic        lk_valid, lk_hit, lk_fault;
  logic [39:0] lk_pa;
  logic        fill_en = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [27:0] fill_ppn = '0;
  logic        fill_global = 1'b0;
  logic [2:0]  ctl_op = 3'd0;
  logic [35:0] ctl_vpn = '0;
  logic [7:0]  ctl_asid = '0;

  always #10 clk = ~clk; // 50 MHz

  tlb_tagged dut (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va), .cur_asid(cur_asid),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pa(lk_pa),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
    .fill_global(fill_global), .ctl_op(ctl_op), .ctl_vpn(ctl_vpn), .ctl_asid(ctl_asid)
  );

  typedef struct {
    logic        hit;
    logic        fault;
    logic [39:0] pa;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   n_vec = 0;
  int   n_bad = 0;

  function automatic logic [63:0] mkva(logic [15:0] hi, logic [35:0] vpn, logic [11:0] off);
    return {hi, vpn, off};
  endfunction

  task automatic look(input logic [63:0] va, input logic [7:0] asid,
                      input logic ehit, input logic efault, input logic [27:0] eppn, input string req);
    exp_t e;
    e.hit = ehit; e.fault = efault; e.pa = {eppn, va[11:0]}; e.req = req;
    @(negedge clk);
    sb.push_back(e);
    lk_req = 1'b1; lk_va = va; cur_asid = asid;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [7:0] asid,
                      input logic [27:0] ppn, input logic glob);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn; fill_global = glob;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic ctl(input logic [2:0] op, input logic [35:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    ctl_op = op; ctl_vpn = vpn; ctl_asid = asid;
    @(negedge clk);
    ctl_op = 3'd0;
  endtask

  // monitor: compare each result in the cycle it is due
  always @(negedge clk) begin
    if (!rst && lk_valid) begin
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected result: act valid=1 exp valid=0 (R2)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (lk_hit !== e.hit || lk_fault !== e.fault || (e.hit && lk_pa !== e.pa)) begin
          n_bad++;
          $display("FAIL %s: act hit=%b fault=%b pa=%h exp hit=%b fault=%b pa=%h",
                   e.req, lk_hit, lk_fault, lk_pa, e.hit, e.fault, e.pa);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act running exp done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if (lk_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: act valid=%b exp 0", lk_valid);
    end
    look(mkva(16'h0, 36'h12345, 12'h567), 8'd3, 0, 0, 28'h0, "R1 empty after reset");

    // R2 R3
    fill(36'h12345, 8'd3, 28'hABC, 0);
    look(mkva(16'h0, 36'h12345, 12'h567), 8'd3, 1, 0, 28'hABC, "R2 hit data");
    look(mkva(16'h0, 36'h12345, 12'h567), 8'd4, 0, 0, 28'h0, "R3 asid mismatch");
    look(mkva(16'h0, 36'h12346, 12'h000), 8'd3, 0, 0, 28'h0, "R3 vpn mismatch");

    // R4 global
    fill(36'h00777, 8'd5, 28'h55, 1);
    look(mkva(16'h0, 36'h00777, 12'hFFF), 8'd9, 1, 0, 28'h55, "R4 global other asid");

    // R5 canonical forms
    fill(36'h800000001, 8'd3, 28'h1234, 0);
    look(mkva(16'hFFFF, 36'h800000001, 12'h010), 8'd3, 1, 0, 28'h1234, "R5 high canonical hit");
    look(mkva(16'h0000, 36'h800000001, 12'h010), 8'd3, 0, 1, 28'h0, "R5 bit47 set upper clear");
    look(mkva(16'h0001, 36'h12345, 12'h567), 8'd3, 0, 1, 28'h0, "R5 stray upper bit");

    // R6 tagged base write keeps all
    ctl(3'd2, 36'h0, 8'd0);
    look(mkva(16'h0, 36'h12345, 12'h001), 8'd3, 1, 0, 28'hABC, "R6 tagged write keeps entry");

    // R9 overwrite
    fill(36'h12345, 8'd3, 28'hDEF, 0);
    look(mkva(16'h0, 36'h12345, 12'h002), 8'd3, 1, 0, 28'hDEF, "R9 overwrite");

    // R7 page invalidate
    fill(36'h12345, 8'd6, 28'h666, 0);
    ctl(3'd3, 36'h12345, 8'd3);
    look(mkva(16'h0, 36'h12345, 12'h0), 8'd3, 0, 0, 28'h0, "R7 page cleared");
    look(mkva(16'h0, 36'h12345, 12'h0), 8'd6, 1, 0, 28'h666, "R7 other asid kept");
    look(mkva(16'h0, 36'h00777, 12'h0), 8'd1, 1, 0, 28'h55, "R7 global kept");

    // R8 asid invalidate
    fill(36'h10, 8'd7, 28'h10, 0);
    fill(36'h11, 8'd7, 28'h11, 0);
    fill(36'h12, 8'd8, 28'h12, 0);
    ctl(3'd4, 36'h0, 8'd7);
    look(mkva(16'h0, 36'h10, 12'h0), 8'd7, 0, 0, 28'h0, "R8 asid cleared a");
    look(mkva(16'h0, 36'h11, 12'h0), 8'd7, 0, 0, 28'h0, "R8 asid cleared b");
    look(mkva(16'h0, 36'h12, 12'h0), 8'd8, 1, 0, 28'h12, "R8 other asid kept");
    look(mkva(16'h0, 36'h00777, 12'h0), 8'd7, 1, 0, 28'h55, "R8 global kept");

    // R6 untagged base write
    ctl(3'd1, 36'h0, 8'd0);
    look(mkva(16'h0, 36'h12, 12'h0), 8'd8, 0, 0, 28'h0, "R6 untagged clears");
    look(mkva(16'hFFFF, 36'h800000001, 12'h0), 8'd3, 0, 0, 28'h0, "R6 untagged clears high");
    look(mkva(16'h0, 36'h00777, 12'h0), 8'd2, 1, 0, 28'h55, "R6 global survives");

    // R10 fill with flush in same cycle is dropped
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 36'h321; fill_asid = 8'd2; fill_ppn = 28'h321; fill_global = 1'b0;
    ctl_op = 3'd1;
    @(negedge clk);
    fill_en = 1'b0; ctl_op = 3'd0;
    look(mkva(16'h0, 36'h321, 12'h0), 8'd2, 0, 0, 28'h0, "R10 fill dropped");

    // R11 replacement: global sits in entry 1, 95 fills take the rest
    for (int i = 0; i < 95; i++) fill(36'h1000 + 36'(i), 8'd1, 28'h1000 + 28'(i), 0);
    look(mkva(16'h0, 36'h105E, 12'h0), 8'd1, 1, 0, 28'h105E, "R11 all stored");
    fill(36'h2000, 8'd1, 28'h2000, 0);
    look(mkva(16'h0, 36'h1000, 12'h0), 8'd1, 0, 0, 28'h0, "R11 entry0 replaced");
    look(mkva(16'h0, 36'h2000, 12'h0), 8'd1, 1, 0, 28'h2000, "R11 new entry");
    look(mkva(16'h0, 36'h00777, 12'h0), 8'd1, 1, 0, 28'h55, "R11 entry1 kept");
    fill(36'h2001, 8'd1, 28'h2001, 0);
    look(mkva(16'h0, 36'h00777, 12'h0), 8'd1, 0, 0, 28'h0, "R11 pointer to entry1");
    look(mkva(16'h0, 36'h1001, 12'h0), 8'd1, 1, 0, 28'h1001, "R11 entry2 kept");
    fill(36'h2002, 8'd1, 28'h2002, 0);
    look(mkva(16'h0, 36'h1001, 12'h0), 8'd1, 0, 0, 28'h0, "R11 pointer to entry2");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing results: act %0d pending exp 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule